// File: doc/BRIEF.md
# Operand Effective-Address Generator

This unit turns an addressing-mode code, a short signed constant from the instruction and the values read from the register file into the byte address of an operand. It handles the pointer update needed by the stepping modes, and it tells the operand sequencer whether the operand needs a memory access at all and whether a second, indirect read follows the first one. The register file, the memory access and the rest of instruction decode sit outside it. It takes the mode field, the constant, two register values (Ri and Rj) and the program counter of the instruction.

One request is accepted per cycle on `in_valid`. All results are registered and appear exactly one cycle later with `out_valid`. The constant is sign-extended to the address width before any sum is formed, and every sum wraps modulo 2^AW. The stepping modes return a new value for Ri along with a write enable. The step is the operand size in bytes, chosen by a two-bit size code. A request that cannot be served, either an unknown mode code or an immediate operand used as a destination, raises `illegal` and produces no address, no access and no write-back.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, all outputs are 0.
- R2: Outputs reflect the request of the previous cycle. When `in_valid` was 0, every output is 0. For every output, a value of 0 is also what "no address", "no access" or "no write-back" means below.
- R3: Mode code 0 (operand is the register itself) gives `need_mem`=0, `need_second`=0, `wb_en`=0, `ea`=0.
- R4: Mode code 1 (absolute) gives `ea` = sext(X) and `need_mem`=1.
- R5: Mode code 2 (immediate) gives `ea`=0 and `need_mem`=0 when `is_dest`=0. When `is_dest`=1 it gives `illegal`=1 and all other results 0.
- R6: Mode code 3 (register indirect) gives `ea` = Ri, `need_mem`=1 and `wb_en`=0.
- R7: Mode code 4 (memory indirect) gives `ea` = sext(X) as the pointer location, with `need_mem`=1 and `need_second`=1. No other mode sets `need_second`.
- R8: Mode code 5 (indexed) gives `ea` = sext(X) + Ri, `need_mem`=1, `wb_en`=0.
- R9: Mode code 6 gives `ea` = Ri + Rj. Mode code 7 gives `ea` = sext(X) + Ri + Rj. Both give `need_mem`=1.
- R10: Mode code 8 (relative) gives `ea` = sext(X) + PC, `need_mem`=1.
- R11: Mode code 9 (post-increment) gives `ea` = Ri, `need_mem`=1, `wb_en`=1 and `wb_val` = Ri + step. The step is 1, 2 or 4 for `op_size` 0, 1, or 2/3 respectively.
- R12: Mode code 10 (pre-decrement) gives `ea` = `wb_val` = Ri - step, `need_mem`=1, `wb_en`=1.
- R13: Mode codes 11 to 15 give `illegal`=1 and all other results 0. Only modes 9 and 10 ever set `wb_en`.
- R14: All address sums and pointer updates wrap modulo 2^AW, and X is treated as a two's-complement value of XW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing-mode code |
| is_dest | input | 1 | Operand is a destination |
| op_size | input | 2 | Operand size code (0:1 byte, 1:2 bytes, 2/3:4 bytes) |
| const_x | input | XW | Signed instruction constant |
| ri_val | input | AW | Value of register Ri |
| rj_val | input | AW | Value of register Rj |
| pc_val | input | AW | Program counter of the instruction |
| out_valid | output | 1 | Result present this cycle |
| ea | output | AW | Effective address |
| need_mem | output | 1 | Operand requires a memory read or write |
| need_second | output | 1 | A second read at the fetched pointer is needed |
| wb_en | output | 1 | Write `wb_val` back to Ri |
| wb_val | output | AW | Updated pointer value for Ri |
| illegal | output | 1 | Request cannot be served |

## Verification
The checker assumes that the request fields are stable and defined whenever `in_valid` is high. It also assumes that they are compared one cycle later against a result that depends only on that single request, because the unit carries no state between requests. The bench satisfies this by changing inputs only on the falling edge and driving defined values in every cycle. It sweeps every mode code, both operand directions, every size code and every constant value. These are combined with register and PC values at the sign and wrap boundaries, so the pointer updates and the sums cross zero and the top of the address space.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] AM_REG   = 4'd0;
    localparam logic [MODE_W-1:0] AM_ABS   = 4'd1;
    localparam logic [MODE_W-1:0] AM_IMM   = 4'd2;
    localparam logic [MODE_W-1:0] AM_RIND  = 4'd3;
    localparam logic [MODE_W-1:0] AM_MIND  = 4'd4;
    localparam logic [MODE_W-1:0] AM_IDX   = 4'd5;
    localparam logic [MODE_W-1:0] AM_BIDX  = 4'd6;
    localparam logic [MODE_W-1:0] AM_BIDXO = 4'd7;
    localparam logic [MODE_W-1:0] AM_REL   = 4'd8;
    localparam logic [MODE_W-1:0] AM_AINC  = 4'd9;
    localparam logic [MODE_W-1:0] AM_ADEC  = 4'd10;

    // Term selection and side effects decoded from the mode field
    typedef struct packed {
        logic use_x;
        logic use_ri;
        logic use_rj;
        logic use_pc;
        logic use_dec;
        logic mem;
        logic second;
        logic wb;
        logic bad;
    } ea_ctrl_t;

endpackage

// File: rtl/ea_mode_ctrl.sv
module ea_mode_ctrl
    import ea_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              is_dest,
    output ea_ctrl_t          ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (mode)
            AM_REG: begin
            end
            AM_ABS: begin
                ctrl.use_x = 1'b1;
                ctrl.mem   = 1'b1;
            end
            AM_IMM: begin
                ctrl.bad = is_dest;
            end
            AM_RIND: begin
                ctrl.use_ri = 1'b1;
                ctrl.mem    = 1'b1;
            end
            AM_MIND: begin
                ctrl.use_x  = 1'b1;
                ctrl.mem    = 1'b1;
                ctrl.second = 1'b1;
            end
            AM_IDX: begin
                ctrl.use_x  = 1'b1;
                ctrl.use_ri = 1'b1;
                ctrl.mem    = 1'b1;
            end
            AM_BIDX: begin
                ctrl.use_ri = 1'b1;
                ctrl.use_rj = 1'b1;
                ctrl.mem    = 1'b1;
            end
            AM_BIDXO: begin
                ctrl.use_x  = 1'b1;
                ctrl.use_ri = 1'b1;
                ctrl.use_rj = 1'b1;
                ctrl.mem    = 1'b1;
            end
            AM_REL: begin
                ctrl.use_x  = 1'b1;
                ctrl.use_pc = 1'b1;
                ctrl.mem    = 1'b1;
            end
            AM_AINC: begin
                ctrl.use_ri = 1'b1;
                ctrl.mem    = 1'b1;
                ctrl.wb     = 1'b1;
            end
            AM_ADEC: begin
                ctrl.use_ri  = 1'b1;
                ctrl.use_dec = 1'b1;
                ctrl.mem     = 1'b1;
                ctrl.wb      = 1'b1;
            end
            default: begin
                ctrl.bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ea_step.sv
module ea_step #(
    parameter int AW = 16
) (
    input  logic [1:0]    op_size,
    input  logic [AW-1:0] ri_val,
    output logic [AW-1:0] neg_step,
    output logic [AW-1:0] ri_inc,
    output logic [AW-1:0] ri_dec
);

    logic [AW-1:0] step;

    always_comb begin
        step = '0;
        unique case (op_size)
            2'd0:    step[0] = 1'b1;
            2'd1:    step[1] = 1'b1;
            default: step[2] = 1'b1;
        endcase
        neg_step = (~step) + AW'(1);
        ri_inc   = ri_val + step;
        ri_dec   = ri_val + neg_step;
    end

endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
    parameter int AW = 16,
    parameter int NT = 3
) (
    input  logic [NT-1:0][AW-1:0] terms,
    output logic [AW-1:0]         sum
);

    logic [NT:0][AW-1:0] acc;

    assign acc[0] = '0;

    for (genvar g = 0; g < NT; g++) begin : g_term
        assign acc[g+1] = acc[g] + terms[g];
    end

    assign sum = acc[NT];

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int XW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MODE_W-1:0] mode,
    input  logic              is_dest,
    input  logic [1:0]        op_size,
    input  logic [XW-1:0]     const_x,
    input  logic [AW-1:0]     ri_val,
    input  logic [AW-1:0]     rj_val,
    input  logic [AW-1:0]     pc_val,
    output logic              out_valid,
    output logic [AW-1:0]     ea,
    output logic              need_mem,
    output logic              need_second,
    output logic              wb_en,
    output logic [AW-1:0]     wb_val,
    output logic              illegal
);

    localparam int NTERM = 3;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] ea;
        logic          mem;
        logic          sec;
        logic          wb;
        logic [AW-1:0] wbv;
        logic          bad;
    } ea_out_t;

    ea_ctrl_t             ctl;
    logic [AW-1:0]        x_ext;
    logic [AW-1:0]        neg_step;
    logic [AW-1:0]        ri_inc;
    logic [AW-1:0]        ri_dec;
    logic [NTERM-1:0][AW-1:0] terms;
    logic [AW-1:0]        sum;
    ea_out_t              res_d;
    ea_out_t              res_q;

    // Constant widening: sign-extend when narrower, otherwise keep low bits
    if (XW < AW) begin : g_sext
        assign x_ext = {{(AW-XW){const_x[XW-1]}}, const_x};
    end else begin : g_trunc
        assign x_ext = const_x[AW-1:0];
    end

    ea_mode_ctrl i_ctrl (
        .mode    (mode),
        .is_dest (is_dest),
        .ctrl    (ctl)
    );

    ea_step #(.AW(AW)) i_step (
        .op_size  (op_size),
        .ri_val   (ri_val),
        .neg_step (neg_step),
        .ri_inc   (ri_inc),
        .ri_dec   (ri_dec)
    );

    always_comb begin
        terms[0] = ctl.use_x  ? x_ext  : '0;
        terms[1] = ctl.use_ri ? ri_val : '0;
        if (ctl.use_rj) begin
            terms[2] = rj_val;
        end else if (ctl.use_pc) begin
            terms[2] = pc_val;
        end else if (ctl.use_dec) begin
            terms[2] = neg_step;
        end else begin
            terms[2] = '0;
        end
    end

    ea_sum #(.AW(AW), .NT(NTERM)) i_sum (
        .terms (terms),
        .sum   (sum)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.vld = 1'b1;
            if (ctl.bad) begin
                res_d.bad = 1'b1;
            end else begin
                res_d.ea  = sum;
                res_d.mem = ctl.mem;
                res_d.sec = ctl.second;
                res_d.wb  = ctl.wb;
                if (ctl.wb) begin
                    res_d.wbv = ctl.use_dec ? ri_dec : ri_inc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.vld;
    assign ea          = res_q.ea;
    assign need_mem    = res_q.mem;
    assign need_second = res_q.sec;
    assign wb_en       = res_q.wb;
    assign wb_val      = res_q.wbv;
    assign illegal     = res_q.bad;

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [3:0]    mode,
    input logic          is_dest,
    input logic [1:0]    op_size,
    input logic [AW-1:0] ri_val,
    input logic          out_valid,
    input logic [AW-1:0] ea,
    input logic          need_mem,
    input logic          need_second,
    input logic          wb_en,
    input logic [AW-1:0] wb_val,
    input logic          illegal
);

    function automatic logic [AW-1:0] step_of(input logic [1:0] sz);
        if (sz == 2'd0) return AW'(1);
        if (sz == 2'd1) return AW'(2);
        return AW'(4);
    endfunction

    assert_reg_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 4'd0) |=> (!need_mem && !wb_en && ea == '0));

    assert_imm_dest_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 4'd2 && is_dest) |=> (illegal && !need_mem && out_valid));

    assert_rind_keeps_ri_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 4'd3) |=> (ea == $past(ri_val) && !wb_en && need_mem));

    assert_second_needs_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        need_second |-> need_mem);

    assert_post_inc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 4'd9) |=>
            (wb_en && ea == $past(ri_val) && wb_val - ea == step_of($past(op_size))));

    assert_pre_dec_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 4'd10) |=>
            (wb_en && ea == wb_val && $past(ri_val) - wb_val == step_of($past(op_size))));

    assert_illegal_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!need_mem && !wb_en && ea == '0 && wb_val == '0));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!need_mem && !wb_en && !illegal && !need_second));

endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .mode        (mode),
    .is_dest     (is_dest),
    .op_size     (op_size),
    .ri_val      (ri_val),
    .out_valid   (out_valid),
    .ea          (ea),
    .need_mem    (need_mem),
    .need_second (need_second),
    .wb_en       (wb_en),
    .wb_val      (wb_val),
    .illegal     (illegal)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;

    localparam int AW = 8;
    localparam int XW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    mode = '0;
    logic          is_dest = 1'b0;
    logic [1:0]    op_size = '0;
    logic [XW-1:0] const_x = '0;
    logic [AW-1:0] ri_val = '0;
    logic [AW-1:0] rj_val = '0;
    logic [AW-1:0] pc_val = '0;
    logic          out_valid;
    logic [AW-1:0] ea;
    logic          need_mem;
    logic          need_second;
    logic          wb_en;
    logic [AW-1:0] wb_val;
    logic          illegal;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ea_gen #(.AW(AW), .XW(XW)) i_ea_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .is_dest(is_dest), .op_size(op_size), .const_x(const_x),
        .ri_val(ri_val), .rj_val(rj_val), .pc_val(pc_val),
        .out_valid(out_valid), .ea(ea), .need_mem(need_mem),
        .need_second(need_second), .wb_en(wb_en), .wb_val(wb_val),
        .illegal(illegal)
    );

    task automatic chk(input string tag, input string field,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, field, act, exp);
        end
    endtask

    // Expected results, computed from the requirements
    logic          e_vld, e_mem, e_sec, e_wb, e_bad;
    logic [AW-1:0] e_ea, e_wbv;
    string         e_tag;

    task automatic expect_of(input logic v, input logic [3:0] m, input logic d,
                             input logic [1:0] sz, input logic [XW-1:0] x,
                             input logic [AW-1:0] ri, input logic [AW-1:0] rj,
                             input logic [AW-1:0] pc);
        logic [AW-1:0] xs;
        logic [AW-1:0] st;
        xs = {{(AW-XW){x[XW-1]}}, x};
        st = (sz == 2'd0) ? 8'd1 : (sz == 2'd1) ? 8'd2 : 8'd4;
        e_vld = v; e_mem = 0; e_sec = 0; e_wb = 0; e_bad = 0; e_ea = 0; e_wbv = 0;
        e_tag = "R2";
        if (v) begin
            case (m)
                4'd0: e_tag = "R3";
                4'd1: begin e_tag = "R4"; e_ea = xs; e_mem = 1; end
                4'd2: begin e_tag = "R5"; e_bad = d; end
                4'd3: begin e_tag = "R6"; e_ea = ri; e_mem = 1; end
                4'd4: begin e_tag = "R7"; e_ea = xs; e_mem = 1; e_sec = 1; end
                4'd5: begin e_tag = "R8"; e_ea = xs + ri; e_mem = 1; end
                4'd6: begin e_tag = "R9"; e_ea = ri + rj; e_mem = 1; end
                4'd7: begin e_tag = "R9"; e_ea = xs + ri + rj; e_mem = 1; end
                4'd8: begin e_tag = "R10"; e_ea = xs + pc; e_mem = 1; end
                4'd9: begin e_tag = "R11"; e_ea = ri; e_mem = 1; e_wb = 1; e_wbv = ri + st; end
                4'd10: begin e_tag = "R12"; e_ea = ri - st; e_mem = 1; e_wb = 1; e_wbv = ri - st; end
                default: begin e_tag = "R13"; e_bad = 1; end
            endcase
        end
    endtask

    task automatic compare_all();
        chk(e_tag, "out_valid", 32'(out_valid), 32'(e_vld));
        chk(e_tag, "ea", 32'(ea), 32'(e_ea));
        chk(e_tag, "need_mem", 32'(need_mem), 32'(e_mem));
        chk(e_tag, "need_second", 32'(need_second), 32'(e_sec));
        chk(e_tag, "wb_en", 32'(wb_en), 32'(e_wb));
        chk(e_tag, "wb_val", 32'(wb_val), 32'(e_wbv));
        chk(e_tag, "illegal", 32'(illegal), 32'(e_bad));
    endtask

    initial begin
        logic [AW-1:0] ri_set [8];
        logic [AW-1:0] rj_set [4];
        logic [AW-1:0] pc_set [4];
        bit pending;
        ri_set = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'h3C, 8'hA5};
        rj_set = '{8'h00, 8'h01, 8'h80, 8'hFF};
        pc_set = '{8'h10, 8'hFF, 8'h00, 8'h81};

        // R1: reset state, with a valid request held during reset
        in_valid = 1'b1; mode = 4'd9; ri_val = 8'h40;
        repeat (3) @(negedge clk);
        e_tag = "R1";
        e_vld = 0; e_mem = 0; e_sec = 0; e_wb = 0; e_bad = 0; e_ea = 0; e_wbv = 0;
        compare_all();
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // Main sweep R3 to R14, one request per cycle
        pending = 0;
        for (int m = 0; m < 16; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int x = 0; x < 16; x++) begin
                        for (int i = 0; i < 8; i++) begin
                            for (int j = 0; j < 4; j++) begin
                                if (pending) compare_all();
                                in_valid = 1'b1;
                                mode     = 4'(m);
                                is_dest  = d[0];
                                op_size  = 2'(s);
                                const_x  = XW'(x);
                                ri_val   = ri_set[i];
                                rj_val   = rj_set[j];
                                pc_val   = pc_set[j];
                                expect_of(1'b1, 4'(m), d[0], 2'(s), XW'(x),
                                          ri_set[i], rj_set[j], pc_set[j]);
                                pending = 1;
                                @(negedge clk);
                            end
                        end
                    end
                end
            end
        end
        compare_all();

        // R2: idle cycles with busy inputs produce all-zero results
        for (int m = 0; m < 16; m++) begin
            in_valid = 1'b0;
            mode     = 4'(m);
            is_dest  = 1'b1;
            const_x  = 4'h9;
            ri_val   = 8'hC3;
            expect_of(1'b0, 4'(m), 1'b1, 2'd0, 4'h9, 8'hC3, 8'h00, 8'h00);
            @(negedge clk);
            compare_all();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule